// File: doc/BRIEF.md
# Flash Write Inhibit and Protect Gate

This block sits at the write-acceptance edge of a parallel NOR flash device model. Every clock it samples the active-low chip enable, output enable and write enable strobes, the device reset pin, a write-protect pin, a low-supply flag and the sector targeted by a pending program or erase. From these it decides two things. First, whether a bus write counts as a command cycle. Second, whether a program or erase aimed at a given sector may proceed.

An accepted bus write comes out as a one-cycle command strobe with its captured address and data. A program or erase request is answered one cycle later with either an allow pulse or a deny pulse. A denial caused by sector protection also raises a sticky violation flag. Supply collapse, a device reset, or a write-protect pin that moves during a command sequence each produce a one-cycle force-to-read pulse. That pulse returns the command logic to read-array mode and clears the violation flag.

A write only counts when the strobe combination persists for a programmable number of clock samples, so short strobe glitches are dropped. At power-up a write combination that is already present is ignored until the strobes have been seen released once.

Top module: `nor_wr_gate`

## Requirements
- R1: A write combination means CE# = 0, WE# = 0 and OE# = 1, sampled with RESET# = 1 and the low-supply flag at 0. A sample with OE# = 0, CE# = 1 or WE# = 1 ends or prevents the combination, and a run ended by OE# = 0 is never accepted.
- R2: After a run of at least GLITCH_CYCLES write-combination samples, the first sample with WE# = 1 or CE# = 1 (OE# = 1, RESET# = 1, supply good) raises `cmd_stb` for exactly one cycle, starting one clock later. `cmd_addr`/`cmd_data` then hold the address and data of the last write-combination sample.
- R3: A write-combination run shorter than GLITCH_CYCLES samples never raises `cmd_stb`.
- R4: While `vlow` = 1, no command is accepted, any run in progress is discarded, and every program/erase request is answered with `op_deny` and no `prot_viol`. A 0→1 change of `vlow` produces a one-cycle `force_read` on the following cycle.
- R5: While RESET# = 0, no command is accepted and requests are denied without `prot_viol`. A 1→0 change of RESET# produces a one-cycle `force_read` on the following cycle.
- R6: `force_read` is 1 during system reset and for the first cycle after it. After system reset, no write is accepted until CE# or WE# has been sampled at 1 at least once.
- R7: `op_allow` or `op_deny` answers each `op_req` one cycle later, never both. A sector index at or above NSEC is denied. For any other sector except the two boot sectors while WP# = 0, a request is allowed exactly when `prot_bits[sector]` is 0 (bit = 1 means protected).
- R8: While WP# = 0, requests to sector BOOT_LO or BOOT_HI are denied whatever their `prot_bits`.
- R9: While WP# = 1, sectors BOOT_LO and BOOT_HI follow their `prot_bits` like any other sector.
- R10: A change of WP# between two consecutive samples while `seq_busy` = 1 produces a one-cycle `force_read` on the following cycle. A request sampled in that same cycle is denied.
- R11: A denial due to protection (supply good, RESET# = 1, no abort) sets `prot_viol` from the next cycle on, and it stays set. Any `force_read` cause clears it, and clearing wins when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | System (power-on) reset, active low |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| pin_rst_n | input | 1 | Device reset pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| vlow | input | 1 | Supply below lockout threshold |
| seq_busy | input | 1 | Command sequence in progress (from decoder) |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| op_req | input | 1 | Program/erase request pulse |
| op_sector | input | SW | Target sector of the request |
| prot_bits | input | NSEC | Stored per-sector protect bits, 1 = protected |
| cmd_stb | output | 1 | One-cycle accepted-command strobe |
| cmd_addr | output | AW | Address of accepted command |
| cmd_data | output | DW | Data of accepted command |
| op_allow | output | 1 | Request may proceed |
| op_deny | output | 1 | Request refused |
| force_read | output | 1 | Return-to-read-array pulse |
| prot_viol | output | 1 | Sticky protection-violation flag |

## Verification
The protection path and the abort path can land in the same cycle: a request to a protected sector can arrive on the very sample where WP# flips during a busy sequence, or where the supply drops. Directed steps line these up exactly and check three things: the request is denied, `force_read` pulses, and `prot_viol` ends up cleared rather than set. A random phase then mixes strobe traffic, WP# flips, supply and reset events and requests, and compares every output on every cycle against a reference model kept in the bench.

// File: rtl/nor_wr_pkg.sv
package nor_wr_pkg;

  // Strobe levels that form a bus write (all pins active low).
  function automatic logic f_wr_combo(input logic ce_n, input logic oe_n, input logic we_n);
    return !ce_n && !we_n && oe_n;
  endfunction

  // Strobe levels that close a write cleanly: WE# or CE# released, OE# still high.
  function automatic logic f_wr_release(input logic ce_n, input logic oe_n, input logic we_n);
    return (ce_n || we_n) && oe_n;
  endfunction

  // Supply and reset pin both allow activity.
  function automatic logic f_env_ok(input logic vlow, input logic pin_rst_n);
    return !vlow && pin_rst_n;
  endfunction

endpackage

// File: rtl/nor_strobe_filter.sv
module nor_strobe_filter
  import nor_wr_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 32,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pin_rst_n,
  input  logic          vlow,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_live,
  output logic          run_full,
  output logic          accept_evt,
  output logic          cmd_stb,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  localparam int CW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(GLITCH_CYCLES);

  logic [CW-1:0] run_q;
  logic          pu_hold_q;

  assign wr_live    = f_wr_combo(ce_n, oe_n, we_n) && f_env_ok(vlow, pin_rst_n) && !pu_hold_q;
  assign run_full   = (run_q == FULL);
  assign accept_evt = run_full && f_wr_release(ce_n, oe_n, we_n) && f_env_ok(vlow, pin_rst_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      pu_hold_q <= 1'b1;
      cmd_stb   <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      if (!wr_live)      run_q <= '0;
      else if (!run_full) run_q <= run_q + CW'(1);
      if (ce_n || we_n)  pu_hold_q <= 1'b0;
      cmd_stb <= accept_evt;
      if (wr_live) begin
        cmd_addr <= addr;
        cmd_data <= din;
      end
    end
  end
endmodule

// File: rtl/nor_mode_ctl.sv
module nor_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow,
  input  logic pin_rst_n,
  input  logic wp_n,
  input  logic seq_busy,
  output logic wp_flip,
  output logic abort_evt,
  output logic force_read
);
  logic vlow_q, prst_q, wp_q;

  // Plain history flops: they follow the pins even during system reset.
  always_ff @(posedge clk) begin
    vlow_q <= vlow;
    prst_q <= pin_rst_n;
    wp_q   <= wp_n;
  end

  assign wp_flip   = seq_busy && (wp_n != wp_q);
  assign abort_evt = (vlow && !vlow_q) || (!pin_rst_n && prst_q) || wp_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_read <= 1'b1;
    else        force_read <= abort_evt;
  end
endmodule

// File: rtl/nor_sector_guard.sv
module nor_sector_guard
  import nor_wr_pkg::*;
#(
  parameter int NSEC    = 40,
  parameter int BOOT_LO = 0,
  parameter int BOOT_HI = NSEC - 1,
  localparam int SW     = $clog2(NSEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_req,
  input  logic [SW-1:0]   op_sector,
  input  logic [NSEC-1:0] prot_bits,
  input  logic            wp_n,
  input  logic            vlow,
  input  logic            pin_rst_n,
  input  logic            abort_evt,
  output logic            sect_locked,
  output logic            prot_hit,
  output logic            op_allow,
  output logic            op_deny,
  output logic            prot_viol
);
  localparam int SPAN = 2 ** SW;
  localparam int PAD  = SPAN - NSEC;

  logic [SPAN-1:0] lock_map;
  logic            boot_hit, gate_open, pass;

  // Indices past the last sector read as protected.
  generate
    if (PAD > 0) begin : g_pad
      assign lock_map = {{PAD{1'b1}}, prot_bits};
    end else begin : g_nopad
      assign lock_map = prot_bits;
    end
  endgenerate

  function automatic logic f_boot_override(input logic [SW-1:0] s, input logic wp);
    return !wp && ((s == SW'(BOOT_LO)) || (s == SW'(BOOT_HI)));
  endfunction

  assign boot_hit    = f_boot_override(op_sector, wp_n);
  assign sect_locked = lock_map[op_sector] || boot_hit;
  assign gate_open   = f_env_ok(vlow, pin_rst_n) && !abort_evt;
  assign pass        = op_req && gate_open && !sect_locked;
  assign prot_hit    = op_req && f_env_ok(vlow, pin_rst_n) && sect_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_allow  <= 1'b0;
      op_deny   <= 1'b0;
      prot_viol <= 1'b0;
    end else begin
      op_allow <= pass;
      op_deny  <= op_req && !pass;
      if (abort_evt)     prot_viol <= 1'b0;
      else if (prot_hit) prot_viol <= 1'b1;
    end
  end
endmodule

// File: rtl/nor_wr_gate.sv
module nor_wr_gate #(
  parameter int AW            = 20,
  parameter int DW            = 32,
  parameter int NSEC          = 40,
  parameter int BOOT_LO       = 0,
  parameter int BOOT_HI       = NSEC - 1,
  parameter int GLITCH_CYCLES = 3,
  localparam int SW           = $clog2(NSEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic            pin_rst_n,
  input  logic            wp_n,
  input  logic            vlow,
  input  logic            seq_busy,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  input  logic            op_req,
  input  logic [SW-1:0]   op_sector,
  input  logic [NSEC-1:0] prot_bits,
  output logic            cmd_stb,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_data,
  output logic            op_allow,
  output logic            op_deny,
  output logic            force_read,
  output logic            prot_viol
);
  // Internal events brought out by name for the checker.
  logic wr_live, run_full, accept_evt;
  logic wp_flip, abort_evt;
  logic sect_locked, prot_hit;

  nor_strobe_filter #(.AW(AW), .DW(DW), .GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pin_rst_n(pin_rst_n), .vlow(vlow), .addr(addr), .din(din),
    .wr_live(wr_live), .run_full(run_full), .accept_evt(accept_evt),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  nor_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .pin_rst_n(pin_rst_n),
    .wp_n(wp_n), .seq_busy(seq_busy), .wp_flip(wp_flip),
    .abort_evt(abort_evt), .force_read(force_read)
  );

  nor_sector_guard #(.NSEC(NSEC), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)) u_guard (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_sector(op_sector),
    .prot_bits(prot_bits), .wp_n(wp_n), .vlow(vlow), .pin_rst_n(pin_rst_n),
    .abort_evt(abort_evt), .sect_locked(sect_locked), .prot_hit(prot_hit),
    .op_allow(op_allow), .op_deny(op_deny), .prot_viol(prot_viol)
  );
endmodule

// File: rtl/nor_wr_gate_chk.sv
module nor_wr_gate_chk #(
  parameter int NSEC          = 40,
  parameter int BOOT_LO       = 0,
  parameter int BOOT_HI       = NSEC - 1,
  parameter int GLITCH_CYCLES = 3,
  localparam int SW           = $clog2(NSEC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          pin_rst_n,
  input logic          wp_n,
  input logic          vlow,
  input logic          seq_busy,
  input logic          op_req,
  input logic [SW-1:0] op_sector,
  input logic          cmd_stb,
  input logic          op_allow,
  input logic          op_deny,
  input logic          force_read,
  input logic          prot_viol
);
  localparam int CW = $clog2(GLITCH_CYCLES + 1);
  logic [CW-1:0] run;

  // Independent count of consecutive write-combination samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!ce_n && !we_n && oe_n && pin_rst_n && !vlow)
      run <= (run == CW'(GLITCH_CYCLES)) ? run : run + CW'(1);
    else run <= '0;
  end

  AST_GLITCH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(run) == CW'(GLITCH_CYCLES))); // R3
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R2
  AST_NO_ACC_LOWV: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !cmd_stb); // R4
  AST_DENY_LOWV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && vlow) |=> (op_deny && !op_allow)); // R4
  AST_FR_LOWV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vlow) |=> force_read); // R4
  AST_NO_ACC_PINRST: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |=> !cmd_stb); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_allow && op_deny)); // R7
  AST_BOOT_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !wp_n && (op_sector == SW'(BOOT_LO) || op_sector == SW'(BOOT_HI)))
      |=> !op_allow); // R8
  AST_FR_WP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && (wp_n != $past(wp_n))) |=> force_read); // R10
  AST_VIOL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_viol) |-> force_read); // R11
endmodule

bind nor_wr_gate nor_wr_gate_chk #(
  .NSEC(NSEC), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI), .GLITCH_CYCLES(GLITCH_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .pin_rst_n(pin_rst_n), .wp_n(wp_n), .vlow(vlow), .seq_busy(seq_busy),
  .op_req(op_req), .op_sector(op_sector), .cmd_stb(cmd_stb),
  .op_allow(op_allow), .op_deny(op_deny), .force_read(force_read),
  .prot_viol(prot_viol)
);

// File: tb/nor_wr_gate_tb.sv
module nor_wr_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20, DW = 32, NSEC = 40, SW = 6, GC = 3;
  localparam int BLO = 0, BHI = NSEC - 1;

  logic clk = 1'b0, rst_n;
  logic ce_n, oe_n, we_n, pin_rst_n, wp_n, vlow, seq_busy, op_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [SW-1:0] op_sector;
  logic [NSEC-1:0] prot_bits;
  logic cmd_stb, op_allow, op_deny, force_read, prot_viol;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  nor_wr_gate #(.AW(AW), .DW(DW), .NSEC(NSEC), .BOOT_LO(BLO), .BOOT_HI(BHI),
                .GLITCH_CYCLES(GC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pin_rst_n(pin_rst_n), .wp_n(wp_n), .vlow(vlow), .seq_busy(seq_busy),
    .addr(addr), .din(din), .op_req(op_req), .op_sector(op_sector),
    .prot_bits(prot_bits), .cmd_stb(cmd_stb), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .op_allow(op_allow), .op_deny(op_deny),
    .force_read(force_read), .prot_viol(prot_viol)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  string cur_tag = "R6";
  bit done = 1'b0;

  // Reference state.
  int m_cnt;
  bit m_pu, m_vlq, m_rq, m_wpq, m_viol;
  bit e_stb, e_allow, e_deny, e_fr;
  logic [AW-1:0] m_ah;
  logic [DW-1:0] m_dh;

  function automatic bit locked_ref(int s, logic [NSEC-1:0] bits, logic wp);
    if (s >= NSEC) return 1'b1;
    if (!wp && (s == BLO || s == BHI)) return 1'b1;
    return bits[s];
  endfunction

  task automatic chk1(string nm, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", cur_tag, nm, act, exp, $time);
    end
  endtask

  task automatic chkv(string nm, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_pu = 1; m_viol = 0; m_ah = '0; m_dh = '0;
    m_vlq = vlow; m_rq = pin_rst_n; m_wpq = wp_n;
    e_stb = 0; e_allow = 0; e_deny = 0; e_fr = 1;
  endtask

  // Advance the reference by one clock edge using the present inputs.
  task automatic model_step();
    bit good, live, rel, ab, lk, pass;
    good = !vlow && pin_rst_n;
    rel  = ce_n || we_n;
    live = !ce_n && !we_n && oe_n && good && !m_pu;
    ab   = (vlow && !m_vlq) || (!pin_rst_n && m_rq) || (seq_busy && (wp_n != m_wpq));
    lk   = locked_ref(int'(op_sector), prot_bits, wp_n);
    pass = op_req && good && !ab && !lk;
    e_stb = (m_cnt == GC) && rel && oe_n && good;
    if (live) begin m_ah = addr; m_dh = din; end
    m_cnt = live ? ((m_cnt < GC) ? m_cnt + 1 : GC) : 0;
    if (rel) m_pu = 0;
    m_vlq = vlow; m_rq = pin_rst_n; m_wpq = wp_n;
    e_fr = ab; e_allow = pass; e_deny = op_req && !pass;
    if (ab) m_viol = 0;
    else if (op_req && good && lk) m_viol = 1;
  endtask

  task automatic compare_all();
    chk1("cmd_stb", cmd_stb, e_stb);
    chkv("cmd_addr", 32'(cmd_addr), 32'(m_ah));
    chkv("cmd_data", cmd_data, m_dh);
    chk1("op_allow", op_allow, e_allow);
    chk1("op_deny", op_deny, e_deny);
    chk1("force_read", force_read, e_fr);
    chk1("prot_viol", prot_viol, m_viol);
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_bus();
    ce_n = 1; we_n = 1; oe_n = 1; op_req = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, int len, bit ce_release);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    repeat (len) cyc();
    if (ce_release) ce_n = 1; else we_n = 1;
    addr = ~a; din = ~d;
    cyc();
    ce_n = 1; we_n = 1;
  endtask

  task automatic req(int s);
    op_req = 1; op_sector = SW'(s);
    cyc();
    op_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; ce_n = 0; we_n = 0; oe_n = 1; pin_rst_n = 1; wp_n = 1;
    vlow = 0; seq_busy = 0; op_req = 0; op_sector = '0; addr = '0; din = '0;
    prot_bits = '0;
    repeat (3) @(negedge clk);
    model_reset();
    // R6: reset state, force_read high during reset.
    compare_all();
    rst_n = 1;
    // R6: write combination present from power-up is not accepted.
    repeat (6) cyc();
    we_n = 1;
    cyc();
    chk1("pu no-accept", cmd_stb, 1'b0);
    cyc();
    chk1("pu no-accept late", cmd_stb, 1'b0);

    cur_tag = "R1";
    wr(20'h12345, 32'hCAFE0001, GC, 0);
    chk1("basic accept", cmd_stb, 1'b1);
    chkv("basic addr", 32'(cmd_addr), 32'h12345);
    cyc();
    chk1("one-cycle strobe", cmd_stb, 1'b0);
    // OE# low ends the run without acceptance.
    ce_n = 0; we_n = 0; oe_n = 1; addr = 20'h00AAA;
    repeat (GC + 1) cyc();
    oe_n = 0; cyc();
    we_n = 1; ce_n = 1; cyc();
    chk1("oe low no accept", cmd_stb, 1'b0);
    oe_n = 1; cyc();
    chk1("oe low no accept later", cmd_stb, 1'b0);

    cur_tag = "R2";
    wr(20'hABCDE, 32'h0BADF00D, GC + 4, 1);
    chk1("ce release accept", cmd_stb, 1'b1);
    chkv("ce release data", cmd_data, 32'h0BADF00D);

    cur_tag = "R3";
    wr(20'h00111, 32'h11111111, GC - 1, 0);
    chk1("short run rejected", cmd_stb, 1'b0);
    wr(20'h00222, 32'h22222222, 1, 1);
    chk1("single sample rejected", cmd_stb, 1'b0);

    cur_tag = "R4";
    ce_n = 0; we_n = 0; addr = 20'h00333;
    repeat (GC) cyc();
    vlow = 1; cyc();
    chk1("fr on supply drop", force_read, 1'b1);
    we_n = 1; ce_n = 1; cyc();
    chk1("no accept in lockout", cmd_stb, 1'b0);
    chk1("fr single", force_read, 1'b0);
    prot_bits = '0; req(5);
    chk1("deny in lockout", op_deny, 1'b1);
    chk1("no viol in lockout", prot_viol, 1'b0);
    vlow = 0; cyc();
    wr(20'h00444, 32'h44444444, GC, 0);
    chk1("accept after recovery", cmd_stb, 1'b1);

    cur_tag = "R5";
    ce_n = 0; we_n = 0;
    repeat (GC) cyc();
    pin_rst_n = 0; cyc();
    chk1("fr on pin reset", force_read, 1'b1);
    we_n = 1; ce_n = 1; cyc();
    chk1("no accept in pin reset", cmd_stb, 1'b0);
    req(6);
    chk1("deny in pin reset", op_deny, 1'b1);
    pin_rst_n = 1; cyc();

    cur_tag = "R7";
    prot_bits = '0; prot_bits[9] = 1'b1;
    req(8);  chk1("unprotected allow", op_allow, 1'b1);
    req(9);  chk1("protected deny", op_deny, 1'b1);
    req(45); chk1("out of range deny", op_deny, 1'b1);

    cur_tag = "R11";
    chk1("viol set", prot_viol, 1'b1);
    req(8);  chk1("viol sticky", prot_viol, 1'b1);

    cur_tag = "R8";
    wp_n = 0; prot_bits = '0;
    req(BLO); chk1("boot lo locked", op_deny, 1'b1);
    req(BHI); chk1("boot hi locked", op_deny, 1'b1);
    req(1);   chk1("inner sector free", op_allow, 1'b1);

    cur_tag = "R9";
    wp_n = 1; cyc();
    req(BLO); chk1("boot lo follows bit 0", op_allow, 1'b1);
    prot_bits[BHI] = 1'b1;
    req(BHI); chk1("boot hi follows bit 1", op_deny, 1'b1);

    cur_tag = "R10";
    // Abort and protected request in the same cycle: deny, pulse, clear.
    seq_busy = 1; wp_n = 0; op_req = 1; op_sector = SW'(BHI);
    cyc(); op_req = 0;
    chk1("flip pulse", force_read, 1'b1);
    chk1("flip deny", op_deny, 1'b1);
    chk1("R11 clear wins", prot_viol, 1'b0);
    cyc();
    chk1("flip pulse single", force_read, 1'b0);
    seq_busy = 0; wp_n = 1; cyc();
    chk1("idle flip ignored", force_read, 1'b0);

    cur_tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 4 == 0) we_n = ~we_n;
      if ($urandom % 6 == 0) ce_n = ~ce_n;
      oe_n = ($urandom % 24 != 0);
      addr = AW'($urandom); din = $urandom;
      if (vlow) vlow = ($urandom % 8 != 0); else vlow = ($urandom % 300 == 0);
      if (!pin_rst_n) pin_rst_n = ($urandom % 6 == 0); else pin_rst_n = ($urandom % 300 != 0);
      if ($urandom % 25 == 0) wp_n = ~wp_n;
      if ($urandom % 10 == 0) seq_busy = ~seq_busy;
      op_req = ($urandom % 3 == 0);
      op_sector = SW'($urandom % 48);
      if ($urandom % 60 == 0) prot_bits = {8'($urandom), $urandom};
      cyc();
    end
    idle_bus(); cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule